// File: doc/BRIEF.md
# Two-Wire Control Register Writer

This block receives write transfers on a two-wire serial bus (SCL clock, SDA data, open-drain) and uses them to load a bank of ten 8-bit control registers for an audio signal processor. Both bus lines are oversampled with the system clock through a synchroniser, and the START and STOP conditions and SCL edges are found on the synchronised copies. A transfer carries the device address byte, then a subaddress byte, then any number of data bytes. Each is acknowledged by pulling SDA low during the ninth clock.

The subaddress picks a register index in its low four bits. Its top bit chooses the transfer's write mode: either every data byte goes to the same register, or the index steps by one after each byte. The step wraps inside a four-bit loop. Indices 10 to 15 hold no register, so bytes that land there are acknowledged and then thrown away. The register contents are presented as one flat parallel bus, register `k` on bits `8k+7 .. 8k`.

The controller is a single state machine with these states: `ST_IDLE`, `ST_RX_ADDR`, `ST_ACK_ADDR`, `ST_RX_SUB`, `ST_ACK_SUB`, `ST_RX_DATA`, `ST_ACK_DATA` and `ST_IGNORE`. Its transitions are:
- START from any state goes to `ST_RX_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_RX_ADDR` goes to `ST_ACK_ADDR` on the SCL fall after the 8th bit when the byte matches. When it does not match, it goes to `ST_IGNORE` on that same fall.
- `ST_ACK_ADDR` goes to `ST_RX_SUB` on the SCL fall that ends the ninth clock.
- `ST_RX_SUB` goes to `ST_ACK_SUB` on the SCL fall after the 8th bit.
- `ST_ACK_SUB` goes to `ST_RX_DATA` on the SCL fall that ends the ninth clock.
- `ST_RX_DATA` and `ST_ACK_DATA` alternate on the same two events.
- `ST_IGNORE` waits for START or STOP.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: A START (SDA falling while SCL is high) moves the block to address reception from any state. This includes a repeated START in the middle of a byte, which abandons that byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R2: Bytes are shifted in MSB first, with one bit sampled per SCL rising edge.
- R3: An address byte equal to 0x80 (device address 7'h40 with the write bit 0) is acknowledged. Any other address byte is not acknowledged, and this includes 0x81 (read requested). In that case SDA stays released, and every following byte up to the next START or STOP is neither acknowledged nor written.
- R4: In the subaddress byte, bit 7 is the increment flag and bits 3..0 are the register index; bits 6..4 have no effect. The subaddress and every data byte of an addressed transfer are acknowledged.
- R5: With the increment flag at 0, every data byte up to STOP is written to the selected register.
- R6: With the increment flag at 1, the first data byte goes to the selected index. Each later byte goes to the previous index plus one, modulo 16.
- R7: A data byte whose index is 10 to 15 changes no register, yet it is still acknowledged.
- R8: After reset, registers 5, 6, 7 and 8 (the speaker and aux attenuators) hold the mute code 0x7F. Register 9 holds 0x03, whose bits 1..0 = 11 select input 1. Registers 0 to 4 hold 0x00. SDA is released.
- R9: A byte cut short by STOP or by a repeated START writes nothing.
- R10: The block pulls SDA low only during an acknowledge clock, and it changes its drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| reg_bus_o | output | NUM_REGS*8 | All control registers, register k on bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: device address 7'h40, ten registers and a two-stage synchroniser. Each SCL quarter period lasts five system clocks. With ten registers behind a four-bit index, six phantom indices remain. An incrementing burst of nine bytes that starts at index 8 therefore crosses all of them and wraps back onto register 0. The bench also cuts bytes short with STOP and with a repeated START, so the abort paths are exercised against a known register image.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_SUB,
        ST_ACK_SUB,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_IGNORE
    } bus_state_e;

    // Power-on contents: attenuators muted, input selector on input 1.
    function automatic logic [DATA_W-1:0] reset_value(input int unsigned idx);
        logic [DATA_W-1:0] v;
        if (idx >= 5 && idx <= 8)
            v = 8'h7F;
        else if (idx == 9)
            v = 8'h03;
        else
            v = 8'h00;
        return v;
    endfunction

endpackage

// File: rtl/i2cw_sync_edge.sv
module i2cw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output bus_state_e        state,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [DATA_W-1:0] WR_ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam int                CNT_W        = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  FULL_CNT     = CNT_W'(DATA_W);

    bus_state_e         nxt;
    logic [DATA_W-1:0]  shreg;
    logic [CNT_W-1:0]   bitcnt;
    logic [IDX_W-1:0]   idx;
    logic               auto_inc;
    logic               byte_done;

    assign byte_done = scl_fall && (bitcnt == FULL_CNT);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_RX_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_RX_ADDR:  if (byte_done) nxt = (shreg == WR_ADDR_BYTE) ? ST_ACK_ADDR : ST_IGNORE;
                ST_ACK_ADDR: if (scl_fall) nxt = ST_RX_SUB;
                ST_RX_SUB:   if (byte_done) nxt = ST_ACK_SUB;
                ST_ACK_SUB:  if (scl_fall) nxt = ST_RX_DATA;
                ST_RX_DATA:  if (byte_done) nxt = ST_ACK_DATA;
                ST_ACK_DATA: if (scl_fall) nxt = ST_RX_DATA;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs: acknowledge drive follows the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= (nxt == ST_ACK_ADDR) || (nxt == ST_ACK_SUB) || (nxt == ST_ACK_DATA);
    end

    // byte shifter, bit counter and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            idx      <= '0;
            auto_inc <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            if ((state == ST_RX_ADDR || state == ST_RX_SUB || state == ST_RX_DATA)
                && scl_rise && bitcnt != FULL_CNT) begin
                shreg  <= {shreg[DATA_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (byte_done) begin
                bitcnt <= '0;
                if (state == ST_RX_SUB) begin
                    idx      <= shreg[IDX_W-1:0];
                    auto_inc <= shreg[DATA_W-1];
                end else if (state == ST_RX_DATA && auto_inc) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign wr_en   = (state == ST_RX_DATA) && byte_done && !start_det && !stop_det;
    assign wr_idx  = idx;
    assign wr_data = shreg;

endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] reg_bus
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= reset_value(g);
            else if (wr_en && wr_idx == IDX_W'(g))
                r <= wr_data;
        end
        assign reg_bus[g*DATA_W +: DATA_W] = r;
    end

endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h40,
    parameter int         NUM_REGS    = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] reg_bus_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    bus_state_e        state;

    i2cw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cw_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .state(state), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    i2cw_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .reg_bus(reg_bus_o)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       start_det,
    input logic                       stop_det,
    input bus_state_e                 state,
    input logic                       sda_oe_o,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [NUM_REGS*DATA_W-1:0] reg_bus_o
);
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> state == ST_RX_ADDR);

    a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    a_r10_drive_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state == ST_ACK_ADDR || state == ST_ACK_SUB || state == ST_ACK_DATA));

    a_r10_drive_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

    a_r7_phantom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) >= NUM_REGS) |=> $stable(reg_bus_o));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |=> $stable(reg_bus_o));

endmodule

bind ctl_i2c_regbank i2cw_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .state(state), .sda_oe_o(sda_oe_o), .wr_en(wr_en),
    .wr_idx(wr_idx), .reg_bus_o(reg_bus_o)
);

// File: tb/sim_ctl_i2c_regbank.sv
module sim_ctl_i2c_regbank;
    localparam int NR = 10;
    localparam int Q  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic [NR*8-1:0] bus;
    logic          sda_line;
    int            n_run = 0;
    int            n_fail = 0;
    logic [7:0]    img [NR];

    always #10 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    ctl_i2c_regbank u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .reg_bus_o(bus)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_image(input string tag);
        for (int i = 0; i < NR; i++) chk(bus[i*8 +: 8], img[i], tag);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NR; i++) img[i] = (i >= 5 && i <= 8) ? 8'h7F : (i == 9 ? 8'h03 : 8'h00);
        chk_image("R8 reset value");
        chk({7'd0, sda_oe}, 8'd0, "R8 sda released");
    endtask

    task automatic t_single_write;
        logic a;
        bus_start;
        send_byte(8'h80, a); chk({7'd0, a}, 8'd1, "R3 address ack");
        send_byte(8'h74, a); chk({7'd0, a}, 8'd1, "R4 subaddress ack");
        send_byte(8'hA5, a); chk({7'd0, a}, 8'd1, "R4 data ack");
        bus_stop;
        img[4] = 8'hA5;
        chk_image("R2 R4 single write, bits 6..4 ignored");
    endtask

    task automatic t_no_inc;
        logic a;
        bus_start;
        send_byte(8'h80, a); send_byte(8'h02, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h3C, a);
        bus_stop;
        img[2] = 8'h3C;
        chk_image("R5 repeated writes to one register");
    endtask

    task automatic t_auto_wrap;
        logic a;
        int acks = 0;
        bus_start;
        send_byte(8'h80, a); send_byte(8'h88, a);
        for (int k = 0; k < 9; k++) begin
            send_byte(8'hC0 + 8'(k), a);
            if (a) acks++;
        end
        bus_stop;
        chk(8'(acks), 8'd9, "R7 phantom bytes acknowledged");
        img[8] = 8'hC0; img[9] = 8'hC1; img[0] = 8'hC8;
        chk_image("R6 R7 increment, drop 10..15, wrap to 0");
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start;
        send_byte(8'h82, a); chk({7'd0, a}, 8'd0, "R3 wrong address nack");
        send_byte(8'h01, a); chk({7'd0, a}, 8'd0, "R3 ignored byte nack");
        send_byte(8'h99, a);
        bus_stop;
        bus_start;
        send_byte(8'h81, a); chk({7'd0, a}, 8'd0, "R3 read bit nack");
        send_byte(8'h03, a); send_byte(8'h55, a);
        bus_stop;
        chk_image("R3 no write when not addressed");
    endtask

    task automatic t_abort;
        logic a;
        bus_start;
        send_byte(8'h80, a); send_byte(8'h06, a);
        send_bits(8'h12, 3);
        bus_stop;
        chk_image("R9 stop mid byte");
        bus_start;
        send_byte(8'h80, a); send_byte(8'h01, a);
        send_bits(8'hFF, 4);
        bus_start;
        send_byte(8'h80, a); chk({7'd0, a}, 8'd1, "R1 repeated start readdress");
        send_byte(8'h01, a); send_byte(8'h6E, a);
        bus_stop;
        img[1] = 8'h6E;
        chk_image("R1 R9 repeated start mid byte");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wq(4); rst_n = 1'b1; wq(4);
        t_reset;
        t_single_write;
        t_no_inc;
        t_auto_wrap;
        t_bad_addr;
        t_abort;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule